// File: doc/BRIEF.md
# Asynchronous Event Dispatcher

This block lives inside a storage controller and pairs asynchronous events raised inside the controller with event-request commands the host has left outstanding. Producers present events, each made of a 3-bit type code, an 8-bit info byte and an 8-bit log page identifier. Accepted events wait in a bounded queue that keeps arrival order. The host side presents request command identifiers. These are held on a last-in first-out stack until an event can complete them.

Each clock, the dispatcher looks for the oldest queued event whose type is not masked. If one exists, at least one request is pending, and the completion register is free or being drained, it emits a completion record. The record pairs the newest pending identifier with the event's fields. Reporting an event masks its type. Masked events stay queued and later events of other types may overtake them. A log-page read without the retain flag unmasks the type tied to that page. A configuration word is held and can be read back. Setting a temperature threshold can raise a health event from inside the block.

Top module: `async_evt_dispatch`

## Requirements
- R1: The queue holds at most QDEPTH events. Fullness is judged on the occupancy at the start of the cycle, and an event offered while full is dropped without trace.
- R2: A request is accepted when fewer than REQ_LIMIT+1 requests are pending. Otherwise it is rejected, and `rq_reject` is high for exactly the cycle after the request.
- R3: A completion always takes the most recently accepted request still pending (LIFO).
- R4: At most one event is dispatched per clock: the oldest queued event whose type bit is clear in the mask. It is dispatched only if a request is pending and the output is empty or accepted that cycle. `cpl_valid` rises after the dispatching edge. Masked events stay queued.
- R5: A dispatch removes the event, sets its type bit in the mask (bit n for type n) and consumes one pending request. The completion carries type, info, page and status 0x00.
- R6: A log read with `lr_retain` low clears mask bit 0 for page 0x01 and mask bit 1 for page 0x02. Any other page, or `lr_retain` high, leaves the mask unchanged. A same-cycle dispatch setting a bit wins over the clear.
- R7: `ctl_clr` empties the queue and the pending stack, and ignores any request or event offered in that cycle. The mask and configuration are kept.
- R8: A configuration write appears on `cfg_rdata` after the next edge.
- R9: With `thr_set` high, a health event is queued if bit 1 of the configuration is set and `temp_now >= thr_hi` or `temp_now <= thr_lo`. The event has type 1, info 0x01 and page 0x02, and it is queued ahead of an external event offered in the same cycle.
- R10: While `cpl_valid` is high and `cpl_ready` low, the completion fields stay unchanged and no event leaves the queue.
- R11: After reset, `cpl_valid` and `rq_reject` are low, `cfg_rdata` is zero and all types are unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_clr | input | 1 | Controller reset: flush queue and pending requests |
| ev_valid | input | 1 | External event offered this cycle |
| ev_kind | input | 3 | Event type code |
| ev_info | input | 8 | Event info byte |
| ev_page | input | 8 | Log page identifier of the event |
| rq_valid | input | 1 | Event-request command offered |
| rq_cid | input | CID_W | Command identifier of the request |
| rq_reject | output | 1 | Previous cycle's request was over the limit |
| lr_valid | input | 1 | Log-page read performed |
| lr_page | input | 8 | Page identifier of the read |
| lr_retain | input | 1 | Read keeps events masked |
| cfg_wr | input | 1 | Configuration word write |
| cfg_wdata | input | CFG_W | Configuration word to write |
| cfg_rdata | output | CFG_W | Current configuration word |
| thr_set | input | 1 | Temperature threshold feature is being set |
| temp_now | input | TEMP_W | Current temperature |
| thr_hi | input | TEMP_W | Upper threshold |
| thr_lo | input | TEMP_W | Lower threshold |
| cpl_valid | output | 1 | Completion record valid |
| cpl_ready | input | 1 | Completion consumer ready |
| cpl_cid | output | CID_W | Identifier of the completed request |
| cpl_kind | output | 3 | Event type reported |
| cpl_info | output | 8 | Event info reported |
| cpl_page | output | 8 | Log page reported |
| cpl_status | output | 8 | Completion status, 0x00 for success |

## Verification
An event, request or log read presented before rising edge k is stored at edge k. It is scanned in the following cycle, and its completion is visible after edge k+1. A rejection and a configuration readback are visible after edge k. The reference model in the bench takes the same inputs at every rising edge. The bench compares against it at the falling edge, one full half-cycle after all registers settle. Directed checks wait on completions recorded at handshakes. A fixed window of idle cycles stands in for "nothing may appear".

// File: rtl/aed_pkg.sv
package aed_pkg;
    localparam int KIND_W  = 3;
    localparam int NKINDS  = 8;
    localparam int INFO_W  = 8;
    localparam int PAGE_W  = 8;
    localparam int CFG_TEMP_BIT = 1;

    localparam logic [KIND_W-1:0] KIND_ERROR  = 3'd0;
    localparam logic [KIND_W-1:0] KIND_HEALTH = 3'd1;
    localparam logic [PAGE_W-1:0] PAGE_ERROR  = 8'h01;
    localparam logic [PAGE_W-1:0] PAGE_HEALTH = 8'h02;
    localparam logic [INFO_W-1:0] INFO_TEMP   = 8'h01;
    localparam logic [7:0]        STATUS_OK   = 8'h00;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [INFO_W-1:0] info;
        logic [PAGE_W-1:0] page;
    } aev_t;

    // Mask bits released by reading a given log page.
    function automatic logic [NKINDS-1:0] page_release(input logic [PAGE_W-1:0] pg);
        logic [NKINDS-1:0] m;
        m = '0;
        if (pg == PAGE_ERROR)  m[KIND_ERROR]  = 1'b1;
        if (pg == PAGE_HEALTH) m[KIND_HEALTH] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/aed_evt_queue.sv
module aed_evt_queue
    import aed_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic [NKINDS-1:0]          mask_i,
    input  logic                       pop_i,
    output logic                       hit_o,
    output aev_t                       ev_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o,
    input  logic                       push_a_v,
    input  aev_t                       push_a,
    input  logic                       push_b_v,
    input  aev_t                       push_b
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        aev_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0] cnt;
    } qst_t;

    qst_t s_q, s_d;
    logic hit;
    logic [IDX_W-1:0] hit_idx;
    logic rm, acc_a, acc_b;
    int   base;

    // Oldest entry whose type is not masked.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = DEPTH-1; i >= 0; i--) begin
            if ((int'(s_q.cnt) > i) && !mask_i[s_q.ent[i].kind]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        s_d   = s_q;
        rm    = pop_i && hit;
        acc_a = push_a_v && (int'(s_q.cnt) < DEPTH);
        acc_b = push_b_v && ((int'(s_q.cnt) + int'(acc_a)) < DEPTH);
        base  = int'(s_q.cnt) - int'(rm);
        if (rm) begin
            for (int i = 0; i < DEPTH-1; i++) begin
                if (i >= int'(hit_idx)) s_d.ent[i] = s_q.ent[i+1];
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (acc_a && i == base) s_d.ent[i] = push_a;
            if (acc_b && i == base + int'(acc_a)) s_d.ent[i] = push_b;
        end
        s_d.cnt = CNT_W'(int'(s_q.cnt) - int'(rm) + int'(acc_a) + int'(acc_b));
        if (flush_i) s_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit_o = hit;
    assign ev_o  = s_q.ent[hit_idx];
    assign cnt_o = s_q.cnt;
endmodule

// File: rtl/aed_req_stack.sv
module aed_req_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] push_d,
    input  logic         pop_i,
    output logic [W-1:0] top_o,
    output logic         nonempty_o,
    output logic         full_o
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [CNT_W-1:0]        cnt;
    } sst_t;

    sst_t s_q, s_d;
    int   wr_idx;
    logic [IDX_W-1:0] top_idx;

    always_comb begin
        s_d    = s_q;
        wr_idx = int'(s_q.cnt) - int'(pop_i);
        if (push_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i == wr_idx) s_d.slot[i] = push_d;
            end
        end
        s_d.cnt = CNT_W'(int'(s_q.cnt) - int'(pop_i) + int'(push_i));
        if (flush_i) s_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign top_idx    = (s_q.cnt == '0) ? '0 : IDX_W'(s_q.cnt - 1'b1);
    assign top_o      = s_q.slot[top_idx];
    assign nonempty_o = (s_q.cnt != '0);
    assign full_o     = (int'(s_q.cnt) == DEPTH);
endmodule

// File: rtl/aed_temp_trig.sv
module aed_temp_trig #(
    parameter int TEMP_W = 16
) (
    input  logic              set_i,
    input  logic              en_i,
    input  logic [TEMP_W-1:0] now_i,
    input  logic [TEMP_W-1:0] hi_i,
    input  logic [TEMP_W-1:0] lo_i,
    output logic              fire_o
);
    logic over, under;
    assign over   = (now_i >= hi_i);
    assign under  = (now_i <= lo_i);
    assign fire_o = set_i && en_i && (over || under);
endmodule

// File: rtl/async_evt_dispatch.sv
module async_evt_dispatch
    import aed_pkg::*;
#(
    parameter int QDEPTH    = 64,
    parameter int REQ_LIMIT = 3,
    parameter int CID_W     = 16,
    parameter int TEMP_W    = 16,
    parameter int CFG_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_clr,
    input  logic              ev_valid,
    input  logic [2:0]        ev_kind,
    input  logic [7:0]        ev_info,
    input  logic [7:0]        ev_page,
    input  logic              rq_valid,
    input  logic [CID_W-1:0]  rq_cid,
    output logic              rq_reject,
    input  logic              lr_valid,
    input  logic [7:0]        lr_page,
    input  logic              lr_retain,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              thr_set,
    input  logic [TEMP_W-1:0] temp_now,
    input  logic [TEMP_W-1:0] thr_hi,
    input  logic [TEMP_W-1:0] thr_lo,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [CID_W-1:0]  cpl_cid,
    output logic [2:0]        cpl_kind,
    output logic [7:0]        cpl_info,
    output logic [7:0]        cpl_page,
    output logic [7:0]        cpl_status
);
    localparam int STK_DEPTH = REQ_LIMIT + 1;
    localparam int QCNT_W    = $clog2(QDEPTH+1);

    typedef struct packed {
        logic [NKINDS-1:0] mask;
        logic [CFG_W-1:0]  cfg;
        logic              rej;
        logic              ov;
        logic [CID_W-1:0]  ocid;
        aev_t              oev;
        logic [7:0]        ost;
    } top_t;

    top_t t_q, t_d;

    logic              q_hit;
    aev_t              q_ev;
    logic [QCNT_W-1:0] q_cnt;
    logic [CID_W-1:0]  stk_top;
    logic              stk_nonempty, stk_full;
    logic              temp_fire;
    logic              out_free, disp_en, disp, rq_ok;
    logic [2:0]        disp_kind;
    aev_t              temp_ev, ext_ev;

    assign temp_ev   = '{kind: KIND_HEALTH, info: INFO_TEMP, page: PAGE_HEALTH};
    assign ext_ev    = '{kind: ev_kind, info: ev_info, page: ev_page};
    assign disp_kind = q_ev.kind;

    assign out_free = !t_q.ov || cpl_ready;
    assign disp_en  = !ctl_clr && stk_nonempty && out_free;
    assign disp     = disp_en && q_hit;
    assign rq_ok    = rq_valid && !stk_full && !ctl_clr;

    aed_temp_trig #(.TEMP_W(TEMP_W)) u_temp (
        .set_i (thr_set),
        .en_i  (t_q.cfg[CFG_TEMP_BIT]),
        .now_i (temp_now),
        .hi_i  (thr_hi),
        .lo_i  (thr_lo),
        .fire_o(temp_fire)
    );

    aed_evt_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (ctl_clr),
        .mask_i  (t_q.mask),
        .pop_i   (disp_en),
        .hit_o   (q_hit),
        .ev_o    (q_ev),
        .cnt_o   (q_cnt),
        .push_a_v(temp_fire && !ctl_clr),
        .push_a  (temp_ev),
        .push_b_v(ev_valid && !ctl_clr),
        .push_b  (ext_ev)
    );

    aed_req_stack #(.DEPTH(STK_DEPTH), .W(CID_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (ctl_clr),
        .push_i    (rq_ok),
        .push_d    (rq_cid),
        .pop_i     (disp),
        .top_o     (stk_top),
        .nonempty_o(stk_nonempty),
        .full_o    (stk_full)
    );

    always_comb begin
        t_d = t_q;
        if (t_q.ov && cpl_ready) t_d.ov = 1'b0;
        t_d.rej = rq_valid && stk_full && !ctl_clr;
        if (lr_valid && !lr_retain) t_d.mask = t_q.mask & ~page_release(lr_page);
        if (disp) begin
            t_d.ov   = 1'b1;
            t_d.ocid = stk_top;
            t_d.oev  = q_ev;
            t_d.ost  = STATUS_OK;
            t_d.mask[q_ev.kind] = 1'b1;
        end
        if (cfg_wr) t_d.cfg = cfg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rq_reject  = t_q.rej;
    assign cfg_rdata  = t_q.cfg;
    assign cpl_valid  = t_q.ov;
    assign cpl_cid    = t_q.ocid;
    assign cpl_kind   = t_q.oev.kind;
    assign cpl_info   = t_q.oev.info;
    assign cpl_page   = t_q.oev.page;
    assign cpl_status = t_q.ost;
endmodule

// File: rtl/aed_dispatch_chk.sv
module aed_dispatch_chk #(
    parameter int CID_W  = 16,
    parameter int CFG_W  = 32,
    parameter int QCNT_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_clr,
    input logic              rq_valid,
    input logic              stk_full,
    input logic              stk_nonempty,
    input logic              rq_reject,
    input logic              cpl_valid,
    input logic              cpl_ready,
    input logic [CID_W-1:0]  cpl_cid,
    input logic [2:0]        cpl_kind,
    input logic [7:0]        cpl_info,
    input logic [7:0]        cpl_page,
    input logic              disp,
    input logic [2:0]        disp_kind,
    input logic [7:0]        mask_q,
    input logic [QCNT_W-1:0] q_cnt,
    input logic              cfg_wr,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic [CFG_W-1:0]  cfg_rdata
);
    p_reject_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && stk_full && !ctl_clr) |=> rq_reject);

    p_no_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rq_valid && stk_full) |=> !rq_reject);

    p_disp_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        disp |=> (cpl_valid && cpl_kind == $past(disp_kind)));

    p_disp_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        disp |=> mask_q[$past(disp_kind)]);

    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clr |=> (q_cnt == '0 && !stk_nonempty));

    p_cfg_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_rdata == $past(cfg_wdata)));

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_cid) && $stable(cpl_kind)
                                       && $stable(cpl_info) && $stable(cpl_page)));

    p_stall_keeps_queue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready && !ctl_clr) |=> (q_cnt >= $past(q_cnt)));
endmodule

bind async_evt_dispatch aed_dispatch_chk #(
    .CID_W (CID_W),
    .CFG_W (CFG_W),
    .QCNT_W($clog2(QDEPTH+1))
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_clr     (ctl_clr),
    .rq_valid    (rq_valid),
    .stk_full    (stk_full),
    .stk_nonempty(stk_nonempty),
    .rq_reject   (rq_reject),
    .cpl_valid   (cpl_valid),
    .cpl_ready   (cpl_ready),
    .cpl_cid     (cpl_cid),
    .cpl_kind    (cpl_kind),
    .cpl_info    (cpl_info),
    .cpl_page    (cpl_page),
    .disp        (disp),
    .disp_kind   (disp_kind),
    .mask_q      (t_q.mask),
    .q_cnt       (q_cnt),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata)
);

// File: tb/async_evt_dispatch_bench.sv
module async_evt_dispatch_bench;
    localparam int QD  = 8;
    localparam int LIM = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_clr = 1'b0;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_kind = '0;
    logic [7:0]  ev_info = '0, ev_page = '0;
    logic        rq_valid = 1'b0;
    logic [15:0] rq_cid = '0;
    logic        rq_reject;
    logic        lr_valid = 1'b0;
    logic [7:0]  lr_page = '0;
    logic        lr_retain = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        thr_set = 1'b0;
    logic [15:0] temp_now = '0, thr_hi = '0, thr_lo = '0;
    logic        cpl_valid, cpl_ready = 1'b1;
    logic [15:0] cpl_cid;
    logic [2:0]  cpl_kind;
    logic [7:0]  cpl_info, cpl_page, cpl_status;

    async_evt_dispatch #(.QDEPTH(QD), .REQ_LIMIT(LIM)) u_async_evt_dispatch (
        .clk(clk), .rst_n(rst_n), .ctl_clr(ctl_clr),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_info(ev_info), .ev_page(ev_page),
        .rq_valid(rq_valid), .rq_cid(rq_cid), .rq_reject(rq_reject),
        .lr_valid(lr_valid), .lr_page(lr_page), .lr_retain(lr_retain),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .thr_set(thr_set), .temp_now(temp_now), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_cid(cpl_cid),
        .cpl_kind(cpl_kind), .cpl_info(cpl_info), .cpl_page(cpl_page),
        .cpl_status(cpl_status)
    );

    always #10 clk = ~clk;

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct { int kind; int info; int page; } mev_t;
    typedef struct { int cid; int kind; int info; int page; } rec_t;

    mev_t       mq[$];
    int         ms[$];
    logic [7:0] mmask;
    logic [31:0] mcfg;
    bit         mrej, mov, fire, run_cmp;
    int         mcid, mkind, minfo, mpage, occ, idx;
    mev_t       de, ne;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); ms.delete();
            mmask = '0; mcfg = '0; mrej = 0; mov = 0;
        end else begin
            occ = mq.size();
            idx = -1;
            if (!ctl_clr && ms.size() > 0 && (!mov || cpl_ready)) begin
                for (int i = 0; i < mq.size(); i++) begin
                    if (idx < 0 && !mmask[mq[i].kind]) idx = i;
                end
            end
            if (mov && cpl_ready) mov = 0;
            mrej = rq_valid && !ctl_clr && (ms.size() > LIM);
            if (lr_valid && !lr_retain) begin
                if (lr_page == 8'h01) mmask[0] = 1'b0;
                if (lr_page == 8'h02) mmask[1] = 1'b0;
            end
            if (idx >= 0) begin
                de = mq[idx];
                mq.delete(idx);
                mov = 1;
                mcid = ms[ms.size()-1];
                ms.delete(ms.size()-1);
                mkind = de.kind; minfo = de.info; mpage = de.page;
                mmask[de.kind] = 1'b1;
            end
            if (ctl_clr) begin
                mq.delete(); ms.delete();
            end else begin
                if (rq_valid && !mrej) ms.push_back(int'(rq_cid));
                fire = thr_set && mcfg[1] && (temp_now >= thr_hi || temp_now <= thr_lo);
                if (fire && occ < QD) begin
                    ne.kind = 1; ne.info = 1; ne.page = 2;
                    mq.push_back(ne);
                    occ++;
                end
                if (ev_valid && occ < QD) begin
                    ne.kind = int'(ev_kind); ne.info = int'(ev_info); ne.page = int'(ev_page);
                    mq.push_back(ne);
                end
            end
            if (cfg_wr) mcfg = cfg_wdata;
        end
    end

    // ---------------- per-cycle comparison and handshake log ----------------
    rec_t got[$];
    rec_t r;

    always @(negedge clk) begin
        #1;
        if (run_cmp) begin
            chk(cpl_valid == mov, "R4", "cpl_valid", cpl_valid, mov);
            if (mov && cpl_valid) begin
                chk(int'(cpl_cid) == mcid, "R3", "cpl_cid", cpl_cid, mcid);
                chk(int'(cpl_kind) == mkind && int'(cpl_info) == minfo && int'(cpl_page) == mpage,
                    "R5", "cpl fields", {cpl_kind, cpl_info, cpl_page}, (mkind << 16) | (minfo << 8) | mpage);
                chk(cpl_status == 8'h00, "R5", "cpl_status", cpl_status, 0);
            end
            chk(rq_reject == mrej, "R2", "rq_reject", rq_reject, mrej);
            chk(cfg_rdata == mcfg, "R8", "cfg_rdata", cfg_rdata, mcfg);
            if (cpl_valid && cpl_ready) begin
                r.cid = int'(cpl_cid); r.kind = int'(cpl_kind);
                r.info = int'(cpl_info); r.page = int'(cpl_page);
                got.push_back(r);
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic post_req(input int cid, output bit rej);
        @(negedge clk); rq_valid = 1; rq_cid = 16'(cid);
        @(negedge clk); rq_valid = 0;
        #2 rej = rq_reject;
    endtask

    task automatic push_ev(input int k, input int i, input int p);
        @(negedge clk); ev_valid = 1; ev_kind = 3'(k); ev_info = 8'(i); ev_page = 8'(p);
        @(negedge clk); ev_valid = 0;
    endtask

    task automatic log_rd(input int p, input bit ret);
        @(negedge clk); lr_valid = 1; lr_page = 8'(p); lr_retain = ret;
        @(negedge clk); lr_valid = 0;
    endtask

    task automatic cfg_write(input int d);
        @(negedge clk); cfg_wr = 1; cfg_wdata = 32'(d);
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic temp_set(input int now, input int hi, input int lo);
        @(negedge clk); thr_set = 1; temp_now = 16'(now); thr_hi = 16'(hi); thr_lo = 16'(lo);
        @(negedge clk); thr_set = 0;
    endtask

    task automatic clr_pulse();
        @(negedge clk); ctl_clr = 1;
        @(negedge clk); ctl_clr = 0;
    endtask

    task automatic expect_cpl(input int cid, input int k, input int i, input int p, input string tag);
        int w = 0;
        rec_t x;
        while (got.size() == 0 && w < 30) begin @(negedge clk); #2; w++; end
        if (got.size() == 0) begin
            chk(0, tag, "completion missing", 0, cid);
        end else begin
            x = got.pop_front();
            chk(x.cid == cid && x.kind == k && x.info == i && x.page == p, tag, "completion",
                (longint'(x.cid) << 24) | (x.kind << 16) | (x.info << 8) | x.page,
                (longint'(cid) << 24) | (k << 16) | (i << 8) | p);
        end
    endtask

    task automatic expect_none(input int n, input string tag);
        repeat (n) @(negedge clk);
        #2;
        chk(got.size() == 0, tag, "unexpected completions", got.size(), 0);
        got.delete();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        bit rj;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #2;
        chk(cpl_valid == 0, "R11", "cpl_valid after reset", cpl_valid, 0);
        chk(rq_reject == 0, "R11", "rq_reject after reset", rq_reject, 0);
        chk(cfg_rdata == 0, "R11", "cfg_rdata after reset", cfg_rdata, 0);
        run_cmp = 1;

        // R3 / R4 / R5: LIFO pairing, masking, overtaking
        post_req(16'h11, rj);
        post_req(16'h22, rj);
        push_ev(2, 8'hA1, 5);
        expect_cpl(16'h22, 2, 8'hA1, 5, "R3");
        push_ev(2, 8'hA2, 5);
        push_ev(3, 8'hB3, 6);
        expect_cpl(16'h11, 3, 8'hB3, 6, "R4");

        // R2: limit of REQ_LIMIT+1 pending requests
        for (int k = 1; k <= 4; k++) begin
            post_req(k, rj);
            chk(rj == 0, "R2", "accepted request flagged", rj, 0);
        end
        post_req(5, rj);
        chk(rj == 1, "R2", "over-limit request not rejected", rj, 1);

        // R6: retain flag and page mapping
        push_ev(0, 8'h10, 1);
        expect_cpl(4, 0, 8'h10, 1, "R3");
        push_ev(0, 8'h11, 1);
        log_rd(1, 1);
        expect_none(6, "R6");
        log_rd(2, 0);
        expect_none(6, "R6");
        log_rd(1, 0);
        expect_cpl(3, 0, 8'h11, 1, "R6");

        // R8 / R9: configuration and temperature events
        cfg_write(32'h2);
        #2 chk(cfg_rdata == 32'h2, "R8", "cfg readback", cfg_rdata, 2);
        temp_set(50, 70, 10);
        expect_none(6, "R9");
        temp_set(80, 70, 10);
        expect_cpl(2, 1, 1, 2, "R9");
        log_rd(2, 0);
        cfg_write(0);
        temp_set(80, 70, 10);
        expect_none(6, "R9");
        cfg_write(32'h2);
        @(negedge clk);
        thr_set = 1; temp_now = 5; thr_hi = 70; thr_lo = 10;
        ev_valid = 1; ev_kind = 4; ev_info = 8'h44; ev_page = 7;
        @(negedge clk);
        thr_set = 0; ev_valid = 0;
        expect_cpl(1, 1, 1, 2, "R9");
        post_req(16'h55, rj);
        expect_cpl(16'h55, 4, 8'h44, 7, "R9");

        // R10: stalled completion
        @(negedge clk); cpl_ready = 0;
        post_req(16'h66, rj);
        post_req(16'h77, rj);
        push_ev(5, 8'h50, 8);
        push_ev(6, 8'h60, 9);
        repeat (4) @(negedge clk);
        #2;
        chk(cpl_valid == 1 && cpl_cid == 16'h77 && cpl_kind == 5, "R10", "held completion",
            {cpl_valid, cpl_cid, cpl_kind}, {1'b1, 16'h77, 3'd5});
        chk(got.size() == 0, "R10", "handshake while stalled", got.size(), 0);
        @(negedge clk); cpl_ready = 1;
        expect_cpl(16'h77, 5, 8'h50, 8, "R10");
        expect_cpl(16'h66, 6, 8'h60, 9, "R10");

        // R1: queue full, extra event dropped (queue holds one masked type-2 entry)
        for (int k = 0; k < 8; k++) push_ev(0, 8'h80 + k, 1);
        for (int k = 0; k < 7; k++) begin
            post_req(16'h90 + k, rj);
            log_rd(1, 0);
            expect_cpl(16'h90 + k, 0, 8'h80 + k, 1, "R1");
        end
        post_req(16'h97, rj);
        log_rd(1, 0);
        expect_none(8, "R1");

        // R7: controller clear
        clr_pulse();
        push_ev(7, 8'h71, 3);
        expect_none(6, "R7");
        clr_pulse();
        post_req(16'hB2, rj);
        expect_none(6, "R7");
        push_ev(7, 8'h72, 3);
        expect_cpl(16'hB2, 7, 8'h72, 3, "R7");

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule